// File: doc/BRIEF.md
# Fault Trap Mode Controller

This block steers a pipelined processor between its ordinary execution mode and a protected safe mode. An external fault sensor raises an alarm line. On the clock edge that samples the alarm, the controller enters safe mode. For the one cycle that follows, it commands a pipeline flush, inhibits register-file and memory writes from the user program, and redirects instruction fetch to a fixed handler entry address. The recovery registers are held frozen for as long as safe mode lasts.

The handler software reports that it has finished through a one-cycle done strobe. The controller returns to the ordinary mode only on a done strobe that arrives while no alarm is present. A fresh alarm during handling neither nests nor gets dropped: it restarts the handler from its entry point, so the handler cannot be skipped by attacking it.

Top module: `fault_trap_ctrl`

## Requirements
- R1: While reset is low and in the first cycle after it, `safe_mode_o`, `frr_freeze_o`, `annul_o`, `rf_wr_block_o`, `mem_wr_block_o` and `redirect_valid_o` are all 0.
- R2: An alarm sampled high at a clock edge while in the ordinary mode makes `safe_mode_o` and `frr_freeze_o` read 1 in the cycle after that edge.
- R3: `annul_o`, `rf_wr_block_o`, `mem_wr_block_o` and `redirect_valid_o` are 1 in the cycle that follows each edge at which the alarm was sampled high, and 0 in every other cycle.
- R4: Whenever `redirect_valid_o` is 1, `redirect_addr_o` equals the parameter `HANDLER_ENTRY`.
- R5: An alarm sampled while already in safe mode keeps `safe_mode_o` at 1 and produces a new one-cycle flush/inhibit/redirect pulse (a handler restart). An alarm held over several edges gives one such pulse for each edge.
- R6: A done strobe sampled in safe mode, with the alarm low and outside the redirect cycle, makes `safe_mode_o` and `frr_freeze_o` read 0 in the next cycle.
- R7: When the alarm and the done strobe are sampled high at the same edge in safe mode, the alarm takes priority: safe mode is kept and the handler restarts.
- R8: A done strobe in the ordinary mode has no effect on any output.
- R9: A done strobe sampled during the redirect cycle has no effect, because the handler has not started yet, so safe mode is kept.
- R10: `frr_freeze_o` stays 1 in every cycle spent in safe mode and is 0 in every cycle spent in the ordinary mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| alarm_i | input | 1 | Fault alarm from the sensor; cannot be masked |
| handler_done_i | input | 1 | Handler completion strobe |
| annul_o | output | 1 | Flush all in-flight pipeline instructions |
| rf_wr_block_o | output | 1 | Inhibit user register-file writes |
| mem_wr_block_o | output | 1 | Inhibit user memory writes |
| frr_freeze_o | output | 1 | Hold the recovery registers |
| redirect_valid_o | output | 1 | Redirect fetch to the handler entry |
| redirect_addr_o | output | ADDR_W | Handler entry address |
| safe_mode_o | output | 1 | 1 in safe mode, 0 in the ordinary mode |

## Verification
The bench builds the controller with `ADDR_W` = 16 and `HANDLER_ENTRY` = 16'hA5C0 instead of the 32-bit defaults. This shows that both the width and the entry value reach the redirect port unchanged. The control path does not depend on these parameters, so the directed scenarios still reach every transition: the alarm held over several edges, alarm and done arriving together, done during the redirect cycle, and done in the ordinary mode.

// File: rtl/ftc_pkg.sv
// Package: shared types for the fault trap mode controller.
// Assumes: nothing beyond a two-valued mode encoding.
package ftc_pkg;
    typedef enum logic {
        MODE_NOMINAL = 1'b0,
        MODE_SAFE    = 1'b1
    } mode_e;
endpackage

// File: rtl/ftc_trap_pulse.sv
// Module: one-cycle trap pulse generator.
// Registers the alarm so that, in the cycle after each sampled alarm,
// a single pulse drives the flush and the two write inhibits.
// Assumes: the alarm is already synchronous to clk.
module ftc_trap_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic alarm_i,
    output logic trap_pulse_o,
    output logic annul_o,
    output logic rf_wr_block_o,
    output logic mem_wr_block_o
);
    logic pulse_q;

    // Capture each sampled alarm as a one-cycle trap entry or restart.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= alarm_i;
    end

    // Fan the pulse out to the flush and inhibit commands.
    always_comb begin
        trap_pulse_o   = pulse_q;
        annul_o        = pulse_q;
        rf_wr_block_o  = pulse_q;
        mem_wr_block_o = pulse_q;
    end
endmodule

// File: rtl/ftc_mode_fsm.sv
// Module: mode state machine (ordinary / safe).
// An alarm always forces safe mode. A done strobe leaves safe mode only
// when no alarm is present and the redirect cycle is over.
// Assumes: handler_done_i is a strobe from the handler software.
module ftc_mode_fsm
    import ftc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  alarm_i,
    input  logic  handler_done_i,
    input  logic  trap_pulse_i,
    output mode_e mode_o
);
    mode_e mode_q, mode_d;

    // Next mode: the alarm has priority, exit needs a clean done.
    always_comb begin
        mode_d = mode_q;
        if (alarm_i)
            mode_d = MODE_SAFE;
        else if (mode_q == MODE_SAFE && handler_done_i && !trap_pulse_i)
            mode_d = MODE_NOMINAL;
    end

    // Mode register, reset to the ordinary mode.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_NOMINAL;
        else        mode_q <= mode_d;
    end

    assign mode_o = mode_q;
endmodule

// File: rtl/ftc_redirect.sv
// Module: fetch redirect driver.
// Presents the handler entry address with a valid flag during the
// trap pulse.
// Assumes: the fetch unit samples the address only while the flag is high.
module ftc_redirect #(
    parameter int unsigned              ADDR_W        = 32,
    parameter logic [ADDR_W-1:0]        HANDLER_ENTRY = '0
) (
    input  logic              trap_pulse_i,
    output logic              redirect_valid_o,
    output logic [ADDR_W-1:0] redirect_addr_o
);
    // Drive the redirect request and its fixed target.
    always_comb begin
        redirect_valid_o = trap_pulse_i;
        redirect_addr_o  = HANDLER_ENTRY;
    end
endmodule

// File: rtl/fault_trap_ctrl.sv
// Module: fault trap mode controller (top).
// Ties together the trap pulse, the mode state machine and the redirect driver.
// Assumes: the alarm and the done strobe are synchronous; reset is synchronous, active low.
module fault_trap_ctrl
    import ftc_pkg::*;
#(
    parameter int unsigned       ADDR_W        = 32,
    parameter logic [ADDR_W-1:0] HANDLER_ENTRY = 32'h0000_0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alarm_i,
    input  logic              handler_done_i,
    output logic              annul_o,
    output logic              rf_wr_block_o,
    output logic              mem_wr_block_o,
    output logic              frr_freeze_o,
    output logic              redirect_valid_o,
    output logic [ADDR_W-1:0] redirect_addr_o,
    output logic              safe_mode_o
);
    logic  trap_pulse;
    mode_e mode;

    ftc_trap_pulse u_pulse (
        .clk            (clk),
        .rst_n          (rst_n),
        .alarm_i        (alarm_i),
        .trap_pulse_o   (trap_pulse),
        .annul_o        (annul_o),
        .rf_wr_block_o  (rf_wr_block_o),
        .mem_wr_block_o (mem_wr_block_o)
    );

    ftc_mode_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .alarm_i        (alarm_i),
        .handler_done_i (handler_done_i),
        .trap_pulse_i   (trap_pulse),
        .mode_o         (mode)
    );

    ftc_redirect #(
        .ADDR_W        (ADDR_W),
        .HANDLER_ENTRY (HANDLER_ENTRY)
    ) u_redir (
        .trap_pulse_i     (trap_pulse),
        .redirect_valid_o (redirect_valid_o),
        .redirect_addr_o  (redirect_addr_o)
    );

    // Mode flag and recovery-register freeze both follow the mode register.
    always_comb begin
        safe_mode_o  = (mode == MODE_SAFE);
        frr_freeze_o = (mode == MODE_SAFE);
    end
endmodule

// File: rtl/ftc_checker.sv
// Module: property checker for fault_trap_ctrl, attached through bind.
// Assumes: it is bound into every instance of fault_trap_ctrl.
module ftc_checker #(
    parameter int unsigned       ADDR_W        = 32,
    parameter logic [ADDR_W-1:0] HANDLER_ENTRY = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              alarm_i,
    input logic              handler_done_i,
    input logic              annul_o,
    input logic              rf_wr_block_o,
    input logic              mem_wr_block_o,
    input logic              frr_freeze_o,
    input logic              redirect_valid_o,
    input logic [ADDR_W-1:0] redirect_addr_o,
    input logic              safe_mode_o
);
    p_reset_nominal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!safe_mode_o && !annul_o && !frr_freeze_o));

    p_enter_safe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_i |=> (safe_mode_o && frr_freeze_o));

    p_pulse_after_alarm_r3: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_i |=> (annul_o && rf_wr_block_o && mem_wr_block_o && redirect_valid_o));

    p_no_stray_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !alarm_i |=> (!annul_o && !rf_wr_block_o && !mem_wr_block_o && !redirect_valid_o));

    p_entry_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid_o |-> (redirect_addr_o == HANDLER_ENTRY));

    p_exit_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (safe_mode_o && handler_done_i && !alarm_i && !redirect_valid_o)
            |=> (!safe_mode_o && !frr_freeze_o));

    p_alarm_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (safe_mode_o && alarm_i && handler_done_i) |=> (safe_mode_o && annul_o));

    p_done_ignored_nominal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!safe_mode_o && !alarm_i) |=> !safe_mode_o);

    p_done_ignored_redirect_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_valid_o && handler_done_i) |=> safe_mode_o);

    p_hold_safe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (safe_mode_o && !handler_done_i) |=> (safe_mode_o && frr_freeze_o));
endmodule

bind fault_trap_ctrl ftc_checker #(
    .ADDR_W        (ADDR_W),
    .HANDLER_ENTRY (HANDLER_ENTRY)
) u_ftc_checker (
    .clk              (clk),
    .rst_n            (rst_n),
    .alarm_i          (alarm_i),
    .handler_done_i   (handler_done_i),
    .annul_o          (annul_o),
    .rf_wr_block_o    (rf_wr_block_o),
    .mem_wr_block_o   (mem_wr_block_o),
    .frr_freeze_o     (frr_freeze_o),
    .redirect_valid_o (redirect_valid_o),
    .redirect_addr_o  (redirect_addr_o),
    .safe_mode_o      (safe_mode_o)
);

// File: tb/test_fault_trap_ctrl.sv
// Bench: directed scenarios for fault_trap_ctrl, one task per scenario.
module test_fault_trap_ctrl;
    localparam int unsigned       ADDR_W = 16;
    localparam logic [ADDR_W-1:0] ENTRY  = 16'hA5C0;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              alarm_i = 1'b0;
    logic              handler_done_i = 1'b0;
    logic              annul_o, rf_wr_block_o, mem_wr_block_o;
    logic              frr_freeze_o, redirect_valid_o, safe_mode_o;
    logic [ADDR_W-1:0] redirect_addr_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    fault_trap_ctrl #(.ADDR_W(ADDR_W), .HANDLER_ENTRY(ENTRY)) i_fault_trap_ctrl (
        .clk              (clk),
        .rst_n            (rst_n),
        .alarm_i          (alarm_i),
        .handler_done_i   (handler_done_i),
        .annul_o          (annul_o),
        .rf_wr_block_o    (rf_wr_block_o),
        .mem_wr_block_o   (mem_wr_block_o),
        .frr_freeze_o     (frr_freeze_o),
        .redirect_valid_o (redirect_valid_o),
        .redirect_addr_o  (redirect_addr_o),
        .safe_mode_o      (safe_mode_o)
    );

    // Compare one observed value with its expectation.
    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Check the mode flags and the pulse group together.
    task automatic chk_state(input string req, input logic safe, input logic pulse);
        chk(req, "safe_mode", {31'd0, safe_mode_o}, {31'd0, safe});
        chk(req, "freeze", {31'd0, frr_freeze_o}, {31'd0, safe});
        chk(req, "annul", {31'd0, annul_o}, {31'd0, pulse});
        chk(req, "rf_block", {31'd0, rf_wr_block_o}, {31'd0, pulse});
        chk(req, "mem_block", {31'd0, mem_wr_block_o}, {31'd0, pulse});
        chk(req, "redirect", {31'd0, redirect_valid_o}, {31'd0, pulse});
    endtask

    // Apply inputs for one edge, then sample just after it.
    task automatic step(input logic a, input logic d);
        @(negedge clk);
        alarm_i = a;
        handler_done_i = d;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset;
        repeat (3) @(posedge clk);
        #1;
        chk_state("R1", 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 1'b0);
        chk_state("R1", 1'b0, 1'b0);
    endtask

    task automatic t_entry_and_exit;
        step(1'b1, 1'b0);
        chk_state("R2", 1'b1, 1'b1);
        chk("R4", "entry", {16'd0, redirect_addr_o}, {16'd0, ENTRY});
        step(1'b0, 1'b0);
        chk_state("R3", 1'b1, 1'b0);
        for (int i = 0; i < 4; i++) begin
            step(1'b0, 1'b0);
            chk_state("R10", 1'b1, 1'b0);
        end
        step(1'b0, 1'b1);
        chk_state("R6", 1'b0, 1'b0);
        step(1'b0, 1'b0);
        chk_state("R10", 1'b0, 1'b0);
    endtask

    task automatic t_restart;
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        chk_state("R5", 1'b1, 1'b1);
        chk("R4", "entry", {16'd0, redirect_addr_o}, {16'd0, ENTRY});
        step(1'b0, 1'b0);
        chk_state("R5", 1'b1, 1'b0);
        step(1'b0, 1'b1);
        chk_state("R6", 1'b0, 1'b0);
    endtask

    task automatic t_held_alarm;
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        chk_state("R5", 1'b1, 1'b1);
        step(1'b1, 1'b0);
        chk_state("R5", 1'b1, 1'b1);
        step(1'b0, 1'b0);
        chk_state("R3", 1'b1, 1'b0);
        step(1'b0, 1'b1);
        chk_state("R6", 1'b0, 1'b0);
    endtask

    task automatic t_alarm_beats_done;
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b1, 1'b1);
        chk_state("R7", 1'b1, 1'b1);
        step(1'b0, 1'b0);
        chk_state("R7", 1'b1, 1'b0);
        step(1'b0, 1'b1);
        chk_state("R6", 1'b0, 1'b0);
    endtask

    task automatic t_done_in_nominal;
        step(1'b0, 1'b1);
        chk_state("R8", 1'b0, 1'b0);
        step(1'b0, 1'b1);
        chk_state("R8", 1'b0, 1'b0);
        step(1'b0, 1'b0);
        chk_state("R8", 1'b0, 1'b0);
    endtask

    task automatic t_done_on_redirect;
        step(1'b1, 1'b0);
        step(1'b0, 1'b1);
        chk_state("R9", 1'b1, 1'b0);
        step(1'b0, 1'b0);
        chk_state("R9", 1'b1, 1'b0);
        step(1'b0, 1'b1);
        chk_state("R6", 1'b0, 1'b0);
    endtask

    initial begin
        t_reset();
        t_entry_and_exit();
        t_restart();
        t_held_alarm();
        t_alarm_beats_done();
        t_done_in_nominal();
        t_done_on_redirect();
        step(1'b0, 1'b0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule